// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block gathers the interrupt conditions of a FIFO-equipped 16550-style UART and condenses them into a 4-bit identification value and a single interrupt line. Two kinds of source are sticky. Receive line errors (overrun, parity, framing, break) are held until software reads the line-status register. Modem-status changes are held until software reads the modem-status register. The receive-data-available and character-timeout conditions are levels owned by the receive FIFO, so they drop when the FIFO drains.

The transmit-holding-empty source has its own gating. If the transmit FIFO has held at least two characters since it last went empty, the interrupt fires as soon as the FIFO empties. Otherwise it waits one character time, not counting the stop bit, measured on the 16x sample tick. This keeps start-up quiet while software loads the first byte. The interrupt clears on a transmit-holding write. It also clears on an identification read, but only when it is the source being reported.

Top module: `uart_irq_ident`

## Requirements
- R1: With no pending source `iid_o` is 4'b0001 and `irq_o` is 0. Whenever a source is pending, bit 0 of `iid_o` is 0 and `irq_o` is 1. This includes the reset state.
- R2: Any bit of `lsr_err_i` makes a line-status interrupt pending from the next cycle, coded 4'b0110. It has the highest priority and clears the cycle after `lsr_rd_i`.
- R3: `rda_i` high shows code 4'b0100 when no line-status interrupt is pending. It outranks timeout, transmit-empty and modem. It follows `rda_i` with no latching.
- R4: `cto_i` high with `rda_i` low and no line-status interrupt shows 4'b1100. It outranks transmit-empty and modem.
- R5: If `tx_level_i` has been 2 or more since the last empty event, code 4'b0010 appears in the cycle after `tx_level_i` is first seen at 0.
- R6: Otherwise transmit-empty asserts after D sample ticks, with D = (6 + `wlen_i` + `par_en_i`) × 16. `wlen_i` counts data bits minus 5. Only cycles with `sample_tick_i` high count. This path is also taken after reset when the FIFO is empty.
- R7: `thr_wr_i` clears a pending transmit-empty interrupt and restarts the delay count from zero. A write wins over a same-cycle set.
- R8: `iir_rd_i` clears transmit-empty only when 4'b0010 is the code shown in that cycle. If a higher source is shown, transmit-empty survives the read.
- R9: Any bit of `msr_delta_i` makes a modem interrupt pending, coded 4'b0000. It has the lowest priority and clears after `msr_rd_i`.
- R10: For the line-status and modem sources, a set in the same cycle as the clearing read wins, and the source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_tick_i | input | 1 | 16x sample-clock enable |
| wlen_i | input | 2 | Data bits minus 5 |
| par_en_i | input | 1 | Parity bit present |
| lsr_err_i | input | 4 | Overrun, parity, framing and break pulses |
| rda_i | input | 1 | Receive level at or above trigger |
| cto_i | input | 1 | Character timeout flag |
| tx_level_i | input | 5 | Transmit FIFO occupancy |
| msr_delta_i | input | 4 | CTS, DSR, RI and DCD change pulses |
| lsr_rd_i | input | 1 | Line-status register read strobe |
| iir_rd_i | input | 1 | Identification register read strobe |
| msr_rd_i | input | 1 | Modem-status register read strobe |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| iid_o | output | 4 | Identification code |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench measures the delayed transmit-empty path to the exact cycle, at two frame lengths. A design that miscounts the character time, or that counts cycles without sample ticks, shows the code one cycle early or late, or while ticks are held off. It also checks that a write partway through the delay restarts the count; a design that only pauses the count would fire early. The identification read is issued both with transmit-empty on top and with a line error masking it. A design that ignores the "highest source" condition loses the masked interrupt. Same-cycle set/clear collisions, and the two-character history that selects the immediate path, complete the cases.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [3:0] {
    IID_NONE = 4'b0001,
    IID_LS   = 4'b0110,
    IID_RDA  = 4'b0100,
    IID_CTO  = 4'b1100,
    IID_THRE = 4'b0010,
    IID_MS   = 4'b0000
  } iid_e;
endpackage

// File: rtl/uart_irq_latch.sv
module uart_irq_latch #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic         pend_o
);
  logic [W-1:0] flag_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[g] <= 1'b0;
      else if (set_i[g]) flag_q[g] <= 1'b1;  // set wins over read
      else if (clr_i)    flag_q[g] <= 1'b0;
    end
  end

  assign pend_o = |flag_q;

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> pend_o);
  // R2 / R9: clearing read empties the latch
  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(|set_i)) |=> !pend_o);
endmodule

// File: rtl/uart_thre_gate.sv
module uart_thre_gate #(
  parameter int LVL_W = 5,
  parameter int OVS   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [1:0]       wlen_i,
  input  logic             par_en_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             wr_i,
  input  logic             ack_i,
  output logic             pend_o
);
  localparam int MAX_DLY = 10 * OVS;
  localparam int CNT_W   = $clog2(MAX_DLY + 1);

  logic             empty, empty_q, held_two_q, run_q, pend_q;
  logic [CNT_W-1:0] cnt_q, dly_ticks;

  assign empty     = (level_i == '0);
  assign dly_ticks = (CNT_W'(wlen_i) + CNT_W'(6) + CNT_W'(par_en_i)) * CNT_W'(OVS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) empty_q <= 1'b0;
    else         empty_q <= empty;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     held_two_q <= 1'b0;
    else if (level_i >= LVL_W'(2))   held_two_q <= 1'b1;
    else if (empty && !empty_q)      held_two_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (wr_i || ack_i) begin
        pend_q <= 1'b0;
        if (wr_i) cnt_q <= '0;
      end else if (empty && !empty_q) begin
        if (held_two_q) pend_q <= 1'b1;
        else begin
          run_q <= 1'b1;
          cnt_q <= '0;
        end
      end else if (!empty) begin
        run_q <= 1'b0;
      end else if (run_q && tick_i) begin
        if (cnt_q == dly_ticks - CNT_W'(1)) begin
          pend_q <= 1'b1;
          run_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign pend_o = pend_q;

  p_wr_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !pend_o);
  p_rise_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o) |-> ($past(held_two_q) || $past(run_q)));
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic ls_i,
  input  logic rda_i,
  input  logic cto_i,
  input  logic thre_i,
  input  logic ms_i,
  output iid_e iid_o
);
  always_comb begin
    if      (ls_i)   iid_o = IID_LS;
    else if (rda_i)  iid_o = IID_RDA;
    else if (cto_i)  iid_o = IID_CTO;
    else if (thre_i) iid_o = IID_THRE;
    else if (ms_i)   iid_o = IID_MS;
    else             iid_o = IID_NONE;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int OVS        = 16,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_tick_i,
  input  logic [1:0]       wlen_i,
  input  logic             par_en_i,
  input  logic [3:0]       lsr_err_i,
  input  logic             rda_i,
  input  logic             cto_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [3:0]       msr_delta_i,
  input  logic             lsr_rd_i,
  input  logic             iir_rd_i,
  input  logic             msr_rd_i,
  input  logic             thr_wr_i,
  output logic [3:0]       iid_o,
  output logic             irq_o
);
  logic ls_pend, ms_pend, thre_pend, thre_ack;
  iid_e iid;

  uart_irq_latch #(.W(4)) u_ls (
    .clk_i, .rst_ni, .set_i(lsr_err_i), .clr_i(lsr_rd_i), .pend_o(ls_pend)
  );

  uart_irq_latch #(.W(4)) u_ms (
    .clk_i, .rst_ni, .set_i(msr_delta_i), .clr_i(msr_rd_i), .pend_o(ms_pend)
  );

  // ID read acknowledges transmit-empty only when it is the reported source
  assign thre_ack = iir_rd_i && (iid == IID_THRE);

  uart_thre_gate #(.LVL_W(LVL_W), .OVS(OVS)) u_thre (
    .clk_i, .rst_ni, .tick_i(sample_tick_i), .wlen_i, .par_en_i,
    .level_i(tx_level_i), .wr_i(thr_wr_i), .ack_i(thre_ack), .pend_o(thre_pend)
  );

  uart_irq_prio u_prio (
    .ls_i(ls_pend), .rda_i, .cto_i, .thre_i(thre_pend), .ms_i(ms_pend), .iid_o(iid)
  );

  assign iid_o = iid;
  assign irq_o = ~iid[0];

  p_ls_top_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ls_pend |-> (iid_o == IID_LS));
  p_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thre_ack |=> (iid_o != IID_THRE));
  p_rda_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rda_i && !ls_pend) |-> (iid_o == IID_RDA));
endmodule

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [1:0] wlen = 2'd0;
  logic       par = 1'b0;
  logic [3:0] lerr = '0, mdel = '0;
  logic       rda = 1'b0, cto = 1'b0;
  logic [4:0] lvl = 5'd1;
  logic       lsr_rd = 1'b0, iir_rd = 1'b0, msr_rd = 1'b0, thr_wr = 1'b0;
  logic [3:0] iid;
  logic       irq;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  uart_irq_ident dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_tick_i(tick), .wlen_i(wlen),
    .par_en_i(par), .lsr_err_i(lerr), .rda_i(rda), .cto_i(cto),
    .tx_level_i(lvl), .msr_delta_i(mdel), .lsr_rd_i(lsr_rd),
    .iir_rd_i(iir_rd), .msr_rd_i(msr_rd), .thr_wr_i(thr_wr),
    .iid_o(iid), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [3:0] exp);
    n_chk++;
    if (iid !== exp || irq !== ~exp[0]) begin
      n_bad++;
      $display("FAIL %s: iid=%b irq=%b expected iid=%b irq=%b", req, iid, irq, exp, ~exp[0]);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 reset", 4'b0001);
    cyc(3);
    chk("R1 idle", 4'b0001);
  endtask

  task automatic t_line_status;
    lerr = 4'b0100; rda = 1'b1; cto = 1'b1; mdel = 4'b0001;
    cyc(1);
    lerr = '0; mdel = '0;
    chk("R2 line status on top", 4'b0110);
    lsr_rd = 1'b1; cyc(1); lsr_rd = 1'b0;
    chk("R3 rda after lsr read", 4'b0100);
    rda = 1'b0;
    #1 chk("R4 timeout below rda", 4'b1100);
    cto = 1'b0;
    #1 chk("R9 modem lowest", 4'b0000);
    msr_rd = 1'b1; cyc(1); msr_rd = 1'b0;
    chk("R9 modem cleared", 4'b0001);
  endtask

  task automatic t_collide;
    lerr = 4'b0001; cyc(1);
    lerr = 4'b1000; lsr_rd = 1'b1; cyc(1);
    lerr = '0; lsr_rd = 1'b0;
    chk("R10 line set beats read", 4'b0110);
    lsr_rd = 1'b1; cyc(1); lsr_rd = 1'b0;
    mdel = 4'b0010; cyc(1);
    mdel = 4'b0100; msr_rd = 1'b1; cyc(1);
    mdel = '0; msr_rd = 1'b0;
    chk("R10 modem set beats read", 4'b0000);
    msr_rd = 1'b1; cyc(1); msr_rd = 1'b0;
    chk("R10 cleared", 4'b0001);
  endtask

  task automatic t_thre_fast;
    lvl = 5'd3; cyc(1);
    lvl = 5'd1; cyc(1);
    lvl = 5'd0; cyc(1);
    chk("R5 immediate empty", 4'b0010);
    lerr = 4'b0010; cyc(1); lerr = '0;
    iir_rd = 1'b1; cyc(1); iir_rd = 1'b0;
    chk("R8 masked read keeps line", 4'b0110);
    lsr_rd = 1'b1; cyc(1); lsr_rd = 1'b0;
    chk("R8 thre survives masked read", 4'b0010);
    iir_rd = 1'b1; cyc(1); iir_rd = 1'b0;
    chk("R8 read clears thre", 4'b0001);
    lvl = 5'd1; cyc(2);
  endtask

  task automatic t_thre_slow(input logic [1:0] w, input logic p);
    int d;
    wlen = w; par = p;
    d = (6 + int'(w) + int'(p)) * 16;
    lvl = 5'd0;
    cyc(d);
    chk("R6 not yet", 4'b0001);
    cyc(1);
    chk("R6 delayed assert", 4'b0010);
    thr_wr = 1'b1; cyc(1); thr_wr = 1'b0;
    chk("R7 write clears", 4'b0001);
    lvl = 5'd1; cyc(2);
  endtask

  task automatic t_thre_restart;
    wlen = 2'd0; par = 1'b0;
    lvl = 5'd0;
    cyc(50);
    thr_wr = 1'b1; cyc(1); thr_wr = 1'b0;
    cyc(95);
    chk("R7 restart no early fire", 4'b0001);
    cyc(1);
    chk("R7 restart fire", 4'b0010);
    thr_wr = 1'b1; cyc(1); thr_wr = 1'b0;
    lvl = 5'd1; cyc(2);
  endtask

  task automatic t_tick_gate;
    wlen = 2'd0; par = 1'b0;
    tick = 1'b0;
    lvl = 5'd0;
    cyc(200);
    chk("R6 no ticks no fire", 4'b0001);
    tick = 1'b1;
    cyc(95);
    chk("R6 ticks resumed not yet", 4'b0001);
    cyc(1);
    chk("R6 ticks resumed fire", 4'b0010);
    thr_wr = 1'b1; cyc(1); thr_wr = 1'b0;
    lvl = 5'd1; cyc(2);
  endtask

  initial begin
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_line_status();
    t_collide();
    t_thre_fast();
    t_thre_slow(2'd0, 1'b0);
    t_thre_slow(2'd3, 1'b1);
    t_thre_restart();
    t_tick_gate();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule